// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple synchronous request port to an asynchronous one-bit-wide dynamic memory whose 18-bit cell address is carried over a 9-bit bus in two halves. Each host request carries an address, a write flag and one data bit. The controller places the upper half of the address on the bus and lowers the row strobe. It then places the lower half on the bus and lowers the column strobe, with the write-enable line set for a read or a write. For a read, it returns the bit the memory drives, together with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row is served by a new column strobe alone. A request to a different row, or a stretch of idle cycles, closes the row and waits out the precharge time. A free-running timer requests a refresh once per interval. The refresh is served as a row-strobe-only cycle that takes its address from an 8-bit row counter, and it wins over any waiting host request. All strobe timings are parameters counted in clock cycles.

Top module: `dram_mux_ctrl`

## Requirements
- R1: During and after reset the row strobe, column strobe and write-enable are all high (inactive) and no read result is flagged. The request port is ready within T_RP+3 cycles after reset is released.
- R2: At the falling row strobe the address bus holds request address bits [17:9]. At the falling column strobe it holds bits [8:0]. Each value is already on the bus one cycle before its strobe falls.
- R3: Write-enable is high at the falling column strobe for a read and low for a write. For a write it is already low one cycle earlier, and the request's data bit is what the memory stores.
- R4: The column strobe goes low only while the row strobe is low. It stays low for exactly T_CAS cycles. After a row activation, its first fall comes exactly T_RCD+1 cycles after the row strobe falls.
- R5: Between any two low periods the row strobe stays high for at least T_RP cycles.
- R6: Each read gives a single-cycle valid pulse. The pulse is visible in the cycle in which the column strobe returns high, and it carries the bit the memory drove during the last low cycle of the column strobe. Writes give no pulse.
- R7: A request to the currently open row is served without raising the row strobe: only the column strobe cycles.
- R8: A request to a row other than the open one raises the row strobe, waits out the precharge, and activates the new row.
- R9: If no request arrives while a row is open, the row strobe rises exactly IDLE_TIMEOUT cycles after the column strobe returns high.
- R10: A refresh cycle is started once every RFSH_INTERVAL clock cycles.
- R11: A refresh cycle keeps the column strobe high and holds the row strobe low for exactly T_RAS_RFSH cycles. The address bus carries a zero top bit and the refresh counter below it. The counter starts at 0 after reset, advances by one per refresh, and wraps from 255 to 0.
- R12: While a refresh is pending the request port is not ready. A pending refresh closes an open row before the next host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_addr | input | 2*MUX_W (18) | Cell address: row in the upper half, column in the lower half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 1 | Read result |
| dram_addr | output | MUX_W (9) | Multiplexed address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data bit to the memory |
| dram_q | input | 1 | Data bit from the memory |

## Verification
The refresh timer and the host port can both want the memory in the same cycle. The hard case is a refresh that falls due in the middle of an unbroken run of same-row hits. The bench provokes this by streaming back-to-back reads to one open row for longer than a refresh interval. It judges the result three ways: at least one row-strobe-only cycle must appear, with the expected counter row, inside the stream. Precharge must be honoured around it. Every read in the stream must still return the bit that was stored earlier. The checker also requires that the port is never ready while a refresh is pending.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [3:0] {
        ST_PRE,    // row strobe high, counting precharge
        ST_IDLE,   // precharged, no row open
        ST_ROW,    // row address on bus, strobe still high
        ST_ACT,    // row strobe low, RAS-to-CAS wait
        ST_COLSU,  // column address and write-enable set up
        ST_CAS,    // column strobe low
        ST_OPEN,   // row open, waiting for a hit
        ST_RFSU,   // refresh row address set up
        ST_RFSH    // refresh row strobe low
    } seq_state_e;

    typedef enum logic [1:0] {
        AS_ROW,
        AS_COL,
        AS_RFSH
    } addr_sel_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/dmc_refresh.sv
module dmc_refresh #(
    parameter int RFSH_W        = 8,
    parameter int RFSH_INTERVAL = 1953
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic              done,
    output logic              pend,
    output logic [RFSH_W-1:0] row
);
    localparam int TMR_W = dmc_pkg::bits_for(RFSH_INTERVAL);

    logic [TMR_W-1:0] tmr;
    logic             tick;

    assign tick = (tmr == TMR_W'(RFSH_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr  <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            tmr <= tick ? '0 : tmr + 1'b1;
            // a fresh tick wins over an acknowledge in the same cycle
            if (tick)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
            if (done)
                row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/dmc_addr_mux.sv
module dmc_addr_mux
    import dmc_pkg::*;
#(
    parameter int MUX_W  = 9,
    parameter int RFSH_W = 8
) (
    input  addr_sel_e         sel,
    input  logic [MUX_W-1:0]  row,
    input  logic [MUX_W-1:0]  col,
    input  logic [RFSH_W-1:0] rfsh_row,
    output logic [MUX_W-1:0]  addr
);
    logic [MUX_W-1:0] rfsh_ext;

    generate
        if (RFSH_W < MUX_W) begin : g_pad
            assign rfsh_ext = {{(MUX_W - RFSH_W){1'b0}}, rfsh_row};
        end else begin : g_trunc
            assign rfsh_ext = rfsh_row[MUX_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            AS_COL:  addr = col;
            AS_RFSH: addr = rfsh_ext;
            default: addr = row;
        endcase
    end
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
    import dmc_pkg::*;
#(
    parameter int MUX_W        = 9,
    parameter int T_RP         = 3,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RAS_RFSH   = 4,
    parameter int IDLE_TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2*MUX_W-1:0] req_addr,
    input  logic               req_we,
    input  logic               req_wdata,
    output logic               rd_valid,
    output logic               rd_data,
    input  logic               dram_q,
    input  logic               rfsh_pend,
    output logic               rfsh_ack,
    output logic               rfsh_done,
    output addr_sel_e          addr_sel,
    output logic [MUX_W-1:0]   row_o,
    output logic [MUX_W-1:0]   col_o,
    output strobe_t            strobe,
    output logic               wdata_o
);
    localparam int CNT_W  = bits_for(max_of4(T_RP, T_RCD, T_CAS, T_RAS_RFSH));
    localparam int IDLE_W = bits_for(IDLE_TIMEOUT);

    seq_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [IDLE_W-1:0]  idle_cnt;
    logic [MUX_W-1:0]   row_q, col_q;
    logic               we_q, wd_q;

    logic [MUX_W-1:0]   req_row, req_col;
    logic               row_hit, host_ok, cnt_zero, idle_exp;

    assign req_row  = req_addr[2*MUX_W-1:MUX_W];
    assign req_col  = req_addr[MUX_W-1:0];
    assign row_hit  = (req_row == row_q);
    assign host_ok  = !rfsh_pend;
    assign cnt_zero = (cnt == '0);
    assign idle_exp = (idle_cnt == IDLE_W'(IDLE_TIMEOUT - 1));

    assign req_ready = host_ok && ((state == ST_IDLE) || (state == ST_OPEN && row_hit));
    assign rfsh_ack  = (state == ST_IDLE) && rfsh_pend;
    assign rfsh_done = (state == ST_RFSH) && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PRE;
            cnt      <= CNT_W'(T_RP - 1);
            idle_cnt <= '0;
            row_q    <= '0;
            col_q    <= '0;
            we_q     <= 1'b0;
            wd_q     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                ST_PRE: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_IDLE: begin
                    if (rfsh_pend) begin
                        state <= ST_RFSU;
                    end else if (req_valid) begin
                        row_q <= req_row;
                        col_q <= req_col;
                        we_q  <= req_we;
                        wd_q  <= req_wdata;
                        state <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    state <= ST_ACT;
                    cnt   <= CNT_W'(T_RCD - 1);
                end
                ST_ACT: begin
                    if (cnt_zero) state <= ST_COLSU;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_COLSU: begin
                    state <= ST_CAS;
                    cnt   <= CNT_W'(T_CAS - 1);
                end
                ST_CAS: begin
                    if (cnt_zero) begin
                        state    <= ST_OPEN;
                        idle_cnt <= '0;
                        if (!we_q) begin
                            rd_valid <= 1'b1;
                            rd_data  <= dram_q;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (rfsh_pend) begin
                        state <= ST_PRE;
                        cnt   <= CNT_W'(T_RP - 1);
                    end else if (req_valid && row_hit) begin
                        col_q <= req_col;
                        we_q  <= req_we;
                        wd_q  <= req_wdata;
                        state <= ST_COLSU;
                    end else if (req_valid || idle_exp) begin
                        state <= ST_PRE;
                        cnt   <= CNT_W'(T_RP - 1);
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                ST_RFSU: begin
                    state <= ST_RFSH;
                    cnt   <= CNT_W'(T_RAS_RFSH - 1);
                end
                ST_RFSH: begin
                    if (cnt_zero) begin
                        state <= ST_PRE;
                        cnt   <= CNT_W'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_PRE;
            endcase
        end
    end

    always_comb begin
        strobe   = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        addr_sel = AS_ROW;
        unique case (state)
            ST_ACT:   strobe.ras_n = 1'b0;
            ST_COLSU: begin
                strobe.ras_n = 1'b0;
                strobe.we_n  = !we_q;
                addr_sel     = AS_COL;
            end
            ST_CAS: begin
                strobe.ras_n = 1'b0;
                strobe.cas_n = 1'b0;
                strobe.we_n  = !we_q;
                addr_sel     = AS_COL;
            end
            ST_OPEN:  begin
                strobe.ras_n = 1'b0;
                addr_sel     = AS_COL;
            end
            ST_RFSU:  addr_sel = AS_RFSH;
            ST_RFSH:  begin
                strobe.ras_n = 1'b0;
                addr_sel     = AS_RFSH;
            end
            default: ;
        endcase
    end

    assign row_o   = row_q;
    assign col_o   = col_q;
    assign wdata_o = wd_q;
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int MUX_W         = 9,
    parameter int RFSH_W        = 8,
    parameter int T_RP          = 3,
    parameter int T_RCD         = 2,
    parameter int T_CAS         = 2,
    parameter int T_RAS_RFSH    = 4,
    parameter int RFSH_INTERVAL = 1953,
    parameter int IDLE_TIMEOUT  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2*MUX_W-1:0] req_addr,
    input  logic               req_we,
    input  logic               req_wdata,
    output logic               rd_valid,
    output logic               rd_data,
    output logic [MUX_W-1:0]   dram_addr,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_d,
    input  logic               dram_q
);
    logic              rfsh_pend, rfsh_ack, rfsh_done;
    logic [RFSH_W-1:0] rfsh_row;
    addr_sel_e         addr_sel;
    logic [MUX_W-1:0]  row_a, col_a;
    strobe_t           strobe;

    dmc_refresh #(
        .RFSH_W        (RFSH_W),
        .RFSH_INTERVAL (RFSH_INTERVAL)
    ) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .ack  (rfsh_ack),
        .done (rfsh_done),
        .pend (rfsh_pend),
        .row  (rfsh_row)
    );

    dmc_seq #(
        .MUX_W        (MUX_W),
        .T_RP         (T_RP),
        .T_RCD        (T_RCD),
        .T_CAS        (T_CAS),
        .T_RAS_RFSH   (T_RAS_RFSH),
        .IDLE_TIMEOUT (IDLE_TIMEOUT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .dram_q    (dram_q),
        .rfsh_pend (rfsh_pend),
        .rfsh_ack  (rfsh_ack),
        .rfsh_done (rfsh_done),
        .addr_sel  (addr_sel),
        .row_o     (row_a),
        .col_o     (col_a),
        .strobe    (strobe),
        .wdata_o   (dram_d)
    );

    dmc_addr_mux #(
        .MUX_W  (MUX_W),
        .RFSH_W (RFSH_W)
    ) u_amux (
        .sel      (addr_sel),
        .row      (row_a),
        .col      (col_a),
        .rfsh_row (rfsh_row),
        .addr     (dram_addr)
    );

    assign dram_ras_n = strobe.ras_n;
    assign dram_cas_n = strobe.cas_n;
    assign dram_we_n  = strobe.we_n;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int MUX_W = 9,
    parameter int T_RP  = 3,
    parameter int T_CAS = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [MUX_W-1:0] addr,
    input logic             rd_valid,
    input logic             req_ready,
    input logic             rfsh_pend
);
    localparam int LEN_W = dmc_pkg::bits_for(((T_RP > T_CAS) ? T_RP : T_CAS) + 1);

    logic [LEN_W-1:0] cas_lo_len, ras_hi_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_lo_len <= '0;
            ras_hi_len <= '0;
        end else begin
            if (!cas_n) cas_lo_len <= (cas_lo_len == '1) ? cas_lo_len : cas_lo_len + 1'b1;
            else        cas_lo_len <= '0;
            if (ras_n)  ras_hi_len <= (ras_hi_len == '1) ? ras_hi_len : ras_hi_len + 1'b1;
            else        ras_hi_len <= '0;
        end
    end

    // R1: strobes inactive and no read flagged right after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n && !rd_valid));

    a_r2_row_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $stable(addr));

    a_r2_col_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $stable(addr));

    a_r3_early_write: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));

    a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    a_r4_cas_width: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> (cas_lo_len == LEN_W'(T_CAS)));

    a_r5_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_hi_len >= LEN_W'(T_RP)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r12_refresh_blocks_host: assert property (@(posedge clk) disable iff (rst)
        rfsh_pend |-> !req_ready);
endmodule

bind dram_mux_ctrl dmc_checker #(
    .MUX_W (MUX_W),
    .T_RP  (T_RP),
    .T_CAS (T_CAS)
) u_dmc_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .addr      (dram_addr),
    .rd_valid  (rd_valid),
    .req_ready (req_ready),
    .rfsh_pend (rfsh_pend)
);

// File: tb/tb_dram_mux_ctrl.sv
module tb_dram_mux_ctrl;
    localparam int MUX_W    = 9;
    localparam int T_RP     = 2;
    localparam int T_RCD    = 2;
    localparam int T_CAS    = 2;
    localparam int T_RASR   = 3;
    localparam int INTERVAL = 200;
    localparam int IDLE_TO  = 6;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [2*MUX_W-1:0] req_addr = '0;
    logic req_we = 1'b0, req_wdata = 1'b0;
    logic rd_valid, rd_data;
    logic [MUX_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_d;
    logic dram_q = 1'b0;

    always #4 clk = ~clk;

    dram_mux_ctrl #(
        .MUX_W(MUX_W), .RFSH_W(8), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RAS_RFSH(T_RASR), .RFSH_INTERVAL(INTERVAL), .IDLE_TIMEOUT(IDLE_TO)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_d(dram_d), .dram_q(dram_q)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // memory model and strobe monitor, sampled at the falling clock edge
    bit mem [int];
    int cyc = 0, ras_hi_len = 0, ras_lo_len = 0, cas_lo_len = 0, since_ras = 0;
    int ras_falls = 0, rfsh_cnt = 0, last_cas_rise = -1, last_ras_rise = -1, key = 0;
    bit p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, cas_seen = 1'b0, last_read = 1'b0;
    logic [MUX_W-1:0] cur_row = '0, last_col = '0;
    logic [7:0] exp_rfsh = '0;

    always @(negedge clk) begin
        if (rst) begin
            p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1;
            ras_hi_len = 0; ras_lo_len = 0; cas_lo_len = 0; exp_rfsh = '0;
        end else begin
            cyc++;
            if (p_ras && !dram_ras_n) begin
                chk(ras_hi_len >= T_RP, "R5 precharge", ras_hi_len, T_RP);
                cur_row = dram_addr; ras_falls++;
                ras_lo_len = 0; since_ras = 0; cas_seen = 1'b0;
            end
            if (!p_ras && dram_ras_n) begin
                last_ras_rise = cyc;
                if (!cas_seen) begin
                    chk(ras_lo_len == T_RASR, "R11 refresh low time", ras_lo_len, T_RASR);
                    chk(cur_row == {1'b0, exp_rfsh}, "R11 refresh row", cur_row, {1'b0, exp_rfsh});
                    exp_rfsh++;
                    rfsh_cnt++;
                end
                ras_hi_len = 0;
            end
            if (p_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R4 cas under ras", dram_ras_n, 0);
                if (!cas_seen) chk(since_ras == T_RCD + 1, "R4 ras-to-cas", since_ras, T_RCD + 1);
                cas_seen = 1'b1;
                last_col = dram_addr;
                key = int'({cur_row, dram_addr});
                if (!dram_we_n) begin
                    chk(!p_we, "R3 early write", p_we, 0);
                    mem[key] = dram_d;
                    last_read = 1'b0;
                end else begin
                    dram_q = mem.exists(key) ? mem[key] : 1'b0;
                    last_read = 1'b1;
                end
                cas_lo_len = 0;
            end
            if (!p_cas && dram_cas_n) begin
                chk(cas_lo_len == T_CAS, "R4 cas width", cas_lo_len, T_CAS);
                last_cas_rise = cyc;
            end
            if (rd_valid)
                chk(cyc == last_cas_rise && last_read, "R6 pulse timing", cyc, last_cas_rise);
            if (!dram_ras_n) begin ras_lo_len++; since_ras++; end
            else ras_hi_len++;
            if (!dram_cas_n) cas_lo_len++;
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
        end
    end

    task automatic host_req(input logic [2*MUX_W-1:0] a, input logic we, input logic wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rd(input logic exp, input string req);
        int n = 0;
        do begin @(negedge clk); n++; end while (!rd_valid && n < 200);
        chk(rd_valid && rd_data == exp, req, rd_data, exp);
    endtask

    task automatic sync_refresh();
        int r0 = rfsh_cnt;
        while (rfsh_cnt == r0) @(negedge clk);
    endtask

    // {address, write, write data, expected read}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {18'h00005, 1'b1, 1'b1, 1'b0},
        {18'h00006, 1'b1, 1'b0, 1'b0},
        {18'h3FE07, 1'b1, 1'b1, 1'b0},
        {18'h00205, 1'b1, 1'b1, 1'b0},
        {18'h00005, 1'b0, 1'b0, 1'b1},
        {18'h00006, 1'b0, 1'b0, 1'b0},
        {18'h3FE07, 1'b0, 1'b0, 1'b1},
        {18'h00205, 1'b0, 1'b0, 1'b1},
        {18'h00007, 1'b0, 1'b0, 1'b0},
        {18'h00006, 1'b1, 1'b1, 1'b0},
        {18'h00006, 1'b0, 1'b0, 1'b1},
        {18'h00005, 1'b1, 1'b0, 1'b0},
        {18'h00005, 1'b0, 1'b0, 1'b0},
        {18'h3FE07, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        int f0, r0;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && !rd_valid, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, rd_valid}, 4'b1110);
        rst = 1'b0;
        repeat (T_RP + 3) @(negedge clk);
        chk(req_ready && !rd_valid && dram_ras_n, "R1 ready after reset",
            {req_ready, rd_valid, dram_ras_n}, 3'b101);

        // table walk: R3 write data stored, R6 read data returned
        for (int i = 0; i < NV; i++) begin
            host_req(VEC[i][20:3], VEC[i][2], VEC[i][1]);
            if (!VEC[i][2]) wait_rd(VEC[i][0], "R3/R6 vector read");
        end

        // R7 page hit, R8 page miss, R2 address halves
        sync_refresh();
        f0 = ras_falls;
        host_req(18'h00005, 1'b0, 1'b0); wait_rd(1'b0, "R6 read row0");
        chk(cur_row == 9'h000 && last_col == 9'h005, "R2 address halves", {cur_row, last_col}, 18'h00005);
        host_req(18'h00006, 1'b0, 1'b0); wait_rd(1'b1, "R7 hit read");
        chk(ras_falls - f0 == 1, "R7 no new activation on hit", ras_falls - f0, 1);
        host_req(18'h3FE07, 1'b0, 1'b0); wait_rd(1'b1, "R8 miss read");
        chk(ras_falls - f0 == 2, "R8 activation on miss", ras_falls - f0, 2);
        chk(cur_row == 9'h1FF && last_col == 9'h007, "R2 row/col of miss", {cur_row, last_col}, 18'h3FE07);

        // R9 idle timeout
        chk(!dram_ras_n, "R9 row still open after access", dram_ras_n, 0);
        repeat (IDLE_TO + T_RP + 4) @(negedge clk);
        chk(last_ras_rise - last_cas_rise == IDLE_TO, "R9 idle close",
            last_ras_rise - last_cas_rise, IDLE_TO);

        // R10 refresh rate
        sync_refresh();
        r0 = rfsh_cnt;
        repeat (5 * INTERVAL) @(negedge clk);
        chk((rfsh_cnt - r0) >= 4 && (rfsh_cnt - r0) <= 6, "R10 refresh rate", rfsh_cnt - r0, 5);

        // R12 refresh colliding with a stream of page hits
        r0 = rfsh_cnt;
        for (int k = 0; k < 120; k++) begin
            host_req((k % 2) ? 18'h00006 : 18'h00005, 1'b0, 1'b0);
            wait_rd((k % 2) ? 1'b1 : 1'b0, "R12 stream read");
        end
        chk(rfsh_cnt - r0 >= 1, "R12 refresh inside hit stream", rfsh_cnt - r0, 1);

        // R11 refresh counter wrap
        while (rfsh_cnt < 258) @(negedge clk);
        chk(exp_rfsh == 8'(rfsh_cnt), "R11 counter wrapped", exp_rfsh, 8'(rfsh_cnt));
        host_req(18'h3FE07, 1'b0, 1'b0); wait_rd(1'b1, "R11 data kept across refresh");

        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (R10/R12 progress): actual %0d cycles expected < %0d", wd, WD_LIMIT);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule